// File: doc/BRIEF.md
# I2C Target with Strap-Selected Address

This block is the bus-facing half of a register interface that sits on a two-wire I2C bus as a target. It watches the clock and data lines through a short synchroniser running on the system clock, recognises start and stop conditions, and shifts in the first byte of every transfer. It then compares the upper seven bits of that byte with its own address. The top four bits of the address are fixed at `1011`. The low three bits come from strap pins, so up to eight of these blocks can share one bus. On the wire they answer to write/read codes B0h/B1h up to BEh/BFh.

When the address matches, the block pulls SDA low for the acknowledge clock. It then either delivers each received byte to the back end as a one-cycle strobe, or it serialises bytes that the back end presents on a read-data input. Transfers may run to any number of bytes. The open-drain pad is split into a sampled line input and an output enable. The enable pulls the line low when it is high. The system clock must run at least eight times faster than the bus bit rate (400 kbit/s at most).

The strap pins are followed only while reset is held. The value present on the last reset cycle becomes the address until the next reset.

Top module: `i2c_strap_target`

## Requirements
- R1: The target address is the 7-bit value {1011, strap}. An address byte whose bits 7..1 equal it is acknowledged: `sda_oe_o` is high throughout the ninth SCL high phase. Bit 0 of the address byte selects the direction (0 = master writes, 1 = master reads).
- R2: The strap value is taken from `strap_i` on the last cycle in which `rst` is high. Later changes of `strap_i` have no effect on which address is acknowledged until the next reset.
- R3: A falling SDA while SCL is high gives a one-cycle `evt_start_o` pulse. A rising SDA while SCL is high gives a one-cycle `evt_stop_o` pulse. Each pulse appears three system clocks after the pin change.
- R4: On an address mismatch the block does not drive SDA, and it raises neither `rx_valid_o` nor `tx_take_o`, until a later start condition.
- R5: In a write, each data byte is taken MSB first on SCL rising edges. `rx_valid_o` pulses for one cycle with the byte on `rx_data_o`, three clocks after the eighth SCL falling edge. The block then acknowledges the byte on the ninth clock. There is no limit on the number of bytes.
- R6: In a read, `tx_data_i` is captured with a one-cycle `tx_take_o` pulse three clocks after the SCL falling edge that ends the address acknowledge, and again after each byte the master acknowledges. The byte is sent MSB first, with `sda_oe_o` equal to the inverse of the bit during SCL high. SDA is released during the master's acknowledge clock.
- R7: If the master does not acknowledge a read byte, the block captures no further data and leaves SDA released until a stop or a start.
- R8: A repeated start returns the block to the address phase. `rw_o` holds the direction bit of the most recently matched address.
- R9: Reset with `rst` high clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 3 | Low address bits, sampled at reset release |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | High pulls SDA low |
| evt_start_o | output | 1 | Start or repeated start seen (pulse) |
| evt_stop_o | output | 1 | Stop seen (pulse) |
| rx_valid_o | output | 1 | Written byte available (pulse) |
| rx_data_o | output | 8 | Written byte |
| rw_o | output | 1 | Direction of the current matched transfer |
| tx_data_i | input | 8 | Next byte to send in a read |
| tx_take_o | output | 1 | `tx_data_i` was captured (pulse) |

## Verification
The bench changes the strap pins after reset and addresses both the old and the new value. A block that followed the pins live would acknowledge the wrong code. Repeated starts between a write and a read check that the address phase restarts; a design that kept its bit count would misread the second address. A master NACK followed by an extra idle clock exposes a design that keeps fetching and driving bytes. A mismatched read exposes one that drives SDA for a transfer it was never addressed in. Strap values 000 and 111 exercise both ends of the address range.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 3;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [6-STRAP_W:0] ADDR_HI = 4'b1011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_RD_WAIT
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [STRAP_W-1:0] lo);
        return b[BYTE_W-1:1] == {ADDR_HI, lo};
    endfunction

endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t ev_o
);
    localparam int LANES = 2;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] now_s;
    logic [LANES-1:0] prev_s;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain     <= '1;
                prev_s[g] <= 1'b1;
            end else begin
                chain     <= {chain[STAGES-2:0], raw[g]};
                prev_s[g] <= chain[STAGES-1];
            end
        end
        assign now_s[g] = chain[STAGES-1];
    end

    always_comb begin
        ev_o.start = now_s[0] & prev_s[0] & prev_s[1] & ~now_s[1];
        ev_o.stop  = now_s[0] & prev_s[0] & ~prev_s[1] & now_s[1];
        ev_o.rise  = now_s[0] & ~prev_s[0];
        ev_o.fall  = ~now_s[0] & prev_s[0];
        ev_o.sda   = now_s[1];
    end

endmodule

// File: rtl/i2c_tgt_strap.sv
module i2c_tgt_strap
    import i2c_tgt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [STRAP_W-1:0] addr_lo_o
);
    always_ff @(posedge clk) begin
        if (rst) addr_lo_o <= strap_i;
    end

    assert_strap_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(addr_lo_o));

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_evt_t           ev,
    input  logic [STRAP_W-1:0] addr_lo,
    input  logic [BYTE_W-1:0]  tx_data_i,
    output logic               sda_oe_o,
    output logic               evt_start_o,
    output logic               evt_stop_o,
    output logic               rx_valid_o,
    output logic [BYTE_W-1:0]  rx_data_o,
    output logic               rw_o,
    output logic               tx_take_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    tgt_state_e        state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            shreg       <= '0;
            cnt         <= '0;
            mack        <= 1'b0;
            sda_oe_o    <= 1'b0;
            evt_start_o <= 1'b0;
            evt_stop_o  <= 1'b0;
            rx_valid_o  <= 1'b0;
            rx_data_o   <= '0;
            rw_o        <= 1'b0;
            tx_take_o   <= 1'b0;
        end else begin
            evt_start_o <= 1'b0;
            evt_stop_o  <= 1'b0;
            rx_valid_o  <= 1'b0;
            tx_take_o   <= 1'b0;
            if (ev.start) begin
                state       <= ST_ADDR;
                cnt         <= '0;
                sda_oe_o    <= 1'b0;
                evt_start_o <= 1'b1;
            end else if (ev.stop) begin
                state      <= ST_IDLE;
                sda_oe_o   <= 1'b0;
                evt_stop_o <= 1'b1;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (ev.rise) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == FULL) begin
                            if (addr_hit(shreg, addr_lo)) begin
                                rw_o     <= shreg[0];
                                sda_oe_o <= 1'b1;
                                state    <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_WR_ACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            if (state == ST_ADDR_ACK && rw_o) begin
                                shreg     <= tx_data_i;
                                sda_oe_o  <= ~tx_data_i[BYTE_W-1];
                                tx_take_o <= 1'b1;
                                state     <= ST_RD_DATA;
                            end else begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_WR_DATA;
                            end
                        end
                    end
                    ST_WR_DATA: begin
                        if (ev.rise) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == FULL) begin
                            rx_valid_o <= 1'b1;
                            rx_data_o  <= shreg;
                            sda_oe_o   <= 1'b1;
                            state      <= ST_WR_ACK;
                        end
                    end
                    ST_RD_DATA: begin
                        if (ev.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.fall) begin
                            if (cnt == FULL) begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_RD_ACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe_o <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.fall) begin
                            cnt <= '0;
                            if (mack) begin
                                shreg     <= tx_data_i;
                                sda_oe_o  <= ~tx_data_i[BYTE_W-1];
                                tx_take_o <= 1'b1;
                                state     <= ST_RD_DATA;
                            end else begin
                                state <= ST_RD_WAIT;
                            end
                        end
                    end
                    ST_RD_WAIT: ;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_idle_released_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe_o);

    assert_nack_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_WAIT) |-> (!sda_oe_o && !tx_take_o));

    assert_rx_only_write_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> !rw_o);

    assert_take_only_read_R6: assert property (@(posedge clk) disable iff (rst)
        tx_take_o |-> rw_o);

    assert_sda_moves_on_low_R5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe_o) && !$past(ev.start) && !$past(ev.stop)) |-> $past(ev.fall));

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] strap_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       evt_start_o,
    output logic       evt_stop_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       rw_o,
    input  logic [7:0] tx_data_i,
    output logic       tx_take_o
);
    bus_evt_t           ev;
    logic [STRAP_W-1:0] addr_lo;

    i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_tgt_strap u_strap (
        .clk       (clk),
        .rst       (rst),
        .strap_i   (strap_i),
        .addr_lo_o (addr_lo)
    );

    i2c_tgt_engine u_eng (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .addr_lo     (addr_lo),
        .tx_data_i   (tx_data_i),
        .sda_oe_o    (sda_oe_o),
        .evt_start_o (evt_start_o),
        .evt_stop_o  (evt_stop_o),
        .rx_valid_o  (rx_valid_o),
        .rx_data_o   (rx_data_o),
        .rw_o        (rw_o),
        .tx_take_o   (tx_take_o)
    );

endmodule

// File: tb/test_i2c_strap_target.sv
module test_i2c_strap_target;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = 8;
    localparam int RING = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] tx_data;
    logic       sda_bus;
    logic       sda_oe, e_start, e_stop, rxv, rw, take;
    logic [7:0] rxd;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_strap_target i_i2c_strap_target (
        .clk(clk), .rst(rst), .strap_i(strap), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .evt_start_o(e_start), .evt_stop_o(e_stop),
        .rx_valid_o(rxv), .rx_data_o(rxd), .rw_o(rw), .tx_data_i(tx_data),
        .tx_take_o(take)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic       x_start [RING];
    logic       x_stop  [RING];
    logic       x_rxv   [RING];
    logic [7:0] x_rxd   [RING];
    logic       x_take  [RING];
    logic [7:0] tx_vals [8] = '{8'hC3, 8'h5A, 8'h01, 8'hFE, 8'h80, 8'h7F, 8'h99, 8'h66};
    int tx_idx = 0;

    logic [2:0] live_strap;
    bit addressed;
    bit is_read;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    initial begin
        for (int i = 0; i < RING; i++) begin
            x_start[i] = 0; x_stop[i] = 0; x_rxv[i] = 0; x_rxd[i] = 0; x_take[i] = 0;
        end
        tx_data = tx_vals[0];
    end

    // per-clock comparison against the bench model's expected pulses
    always @(negedge clk) begin
        automatic int k = cyc % RING;
        chk(e_start === x_start[k], "R3 start pulse", e_start, x_start[k]);
        chk(e_stop === x_stop[k], "R3 stop pulse", e_stop, x_stop[k]);
        chk(rxv === x_rxv[k], "R5 rx_valid", rxv, x_rxv[k]);
        if (x_rxv[k]) chk(rxd === x_rxd[k], "R5 rx_data", rxd, x_rxd[k]);
        chk(take === x_take[k], "R6 tx_take", take, x_take[k]);
        x_start[k] = 0; x_stop[k] = 0; x_rxv[k] = 0; x_take[k] = 0;
        if (take === 1'b1) begin
            tx_idx = tx_idx + 1;
            tx_data = tx_vals[tx_idx % 8];
        end
        cyc = cyc + 1;
    end

    function automatic int slot();
        return (cyc + 2) % RING;
    endfunction

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [2:0] s);
        @(negedge clk); #1;
        rst = 1'b1;
        strap = s;
        repeat (4) @(negedge clk);
        #1;
        rst = 1'b0;
        live_strap = s;
        addressed = 0;
        repeat (4) @(negedge clk);
        #1;
        chk(sda_oe === 1'b0 && rw === 1'b0 && rxv === 1'b0 && take === 1'b0,
            "R9 reset outputs", {sda_oe, rw, rxv, take}, 0);
    endtask

    task automatic bus_start();
        wait_q(); sda_m = 1'b1;
        wait_q(); scl_m = 1'b1;
        wait_q(); sda_m = 1'b0; x_start[slot()] = 1;
        addressed = 0;
        wait_q(); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_q(); sda_m = 1'b0;
        wait_q(); scl_m = 1'b1;
        wait_q(); sda_m = 1'b1; x_stop[slot()] = 1;
        addressed = 0;
        wait_q();
    endtask

    task automatic clk_bit(input logic b, output logic oe_seen);
        wait_q(); sda_m = b;
        wait_q(); scl_m = 1'b1;
        wait_q(); oe_seen = sda_oe;
        wait_q(); scl_m = 1'b0;
    endtask

    task automatic send_addr(input logic [6:0] a, input logic dir);
        logic oe;
        bit hit;
        for (int i = 6; i >= 0; i--) clk_bit(a[i], oe);
        clk_bit(dir, oe);
        hit = (a == {4'b1011, live_strap});
        clk_bit(1'b1, oe);
        chk(oe === hit, hit ? "R1 address ack" : "R4 mismatch no ack", oe, hit);
        addressed = hit;
        is_read = dir;
        if (hit && dir) x_take[slot()] = 1;
        if (hit) chk(rw === dir, "R8 rw_o direction", rw, dir);
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic oe;
        bit want;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], oe);
        want = addressed && !is_read;
        if (want) begin
            x_rxv[slot()] = 1;
            x_rxd[slot()] = b;
        end
        clk_bit(1'b1, oe);
        chk(oe === want, want ? "R5 data ack" : "R4 no data ack", oe, want);
    endtask

    task automatic read_byte(input logic [7:0] expv, input bit m_ack);
        logic oe;
        bit on;
        on = addressed && is_read;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, oe);
            chk(oe === (on ? ~expv[i] : 1'b0), on ? "R6 read bit" : "R4 read quiet",
                oe, on ? ~expv[i] : 1'b0);
        end
        clk_bit(m_ack ? 1'b0 : 1'b1, oe);
        chk(oe === 1'b0, "R6 released on master ack", oe, 0);
        if (on && m_ack) x_take[slot()] = 1;
        if (!m_ack) addressed = 0;
    endtask

    initial begin
        logic oe;
        do_reset(3'b101);

        // multi-byte write to 0x5D
        bus_start();
        send_addr(7'h5D, 1'b0);
        send_byte(8'hA5);
        send_byte(8'h3C);
        send_byte(8'hFF);
        send_byte(8'h00);
        send_byte(8'h81);
        bus_stop();

        // strap changes after reset must not move the address
        strap = 3'b010;
        bus_start();
        send_addr(7'h5A, 1'b0);
        send_byte(8'h77);
        bus_stop();
        bus_start();
        send_addr(7'h5D, 1'b0);
        send_byte(8'h42);
        bus_stop();

        // write, repeated start, read three bytes ending in NACK
        bus_start();
        send_addr(7'h5D, 1'b0);
        send_byte(8'h12);
        bus_start();
        send_addr(7'h5D, 1'b1);
        read_byte(tx_vals[tx_idx % 8], 1'b1);
        read_byte(tx_vals[tx_idx % 8], 1'b1);
        read_byte(tx_vals[tx_idx % 8], 1'b0);
        clk_bit(1'b1, oe);
        chk(oe === 1'b0, "R7 quiet after nack", oe, 0);
        bus_stop();

        // mismatched read stays off the bus
        bus_start();
        send_addr(7'h5C, 1'b1);
        read_byte(8'h00, 1'b1);
        bus_stop();

        // address range ends
        do_reset(3'b000);
        bus_start();
        send_addr(7'h5D, 1'b0);
        bus_stop();
        bus_start();
        send_addr(7'h58, 1'b0);
        send_byte(8'h5A);
        bus_stop();

        do_reset(3'b111);
        bus_start();
        send_addr(7'h5F, 1'b1);
        read_byte(tx_vals[tx_idx % 8], 1'b0);
        bus_stop();

        repeat (8) @(negedge clk);
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule